// File: doc/BRIEF.md
# Serial Flash Controller Register Front End

This block is the register-facing half of a serial flash controller. A simple 32-bit register bus (select, write, address, write data, and read data returned in the same cycle) reaches four configuration words: control, frames, frames extension and interrupt enable. It also reaches a status word and four data ports. The configuration words drive the serial engine directly. The data ports connect the bus to a transmit byte FIFO and a receive byte FIFO.

The serial engine sits outside this block. It pops transmit bytes, pushes receive bytes, pulses its transfer-complete events and reports whether it is ready. Status bits either latch those events (cleared by writing 1) or follow FIFO fill levels. A single interrupt line combines the enabled status bits.

Bit 16 of the control word is the wide-access flag. While it is set, each access to the word data ports moves four FIFO bytes, and byte lane 0 maps to the oldest byte. While it is clear, the word ports behave like the byte ports.

Top module: `sflash_regfront`

## Requirements
- R1: After reset, the control, frames, extension and interrupt enable words read 0, both FIFOs are empty, `irq` is 0, and status reads 0x18 plus bit 7 following `engReady`.
- R2: Register offsets are: control 0x00, frames 0x04, interrupt enable 0x0C, status 0x10, frames extension 0x50. Control, frames and extension store all 32 written bits, read them back and appear on `ctrlWord`, `framesWord` and `framesExt`. Interrupt enable stores bits 5:0 only and reads the other bits as 0.
- R3: Status bit 8 reads the current value of control bit 16, the wide-access flag.
- R4: Writing the status register clears each of bits 0, 1 and 2 that has a 1 in the write data. A 0 leaves the bit unchanged. If a setting event arrives in the same cycle as the clear, the bit stays set.
- R5: A pulse on `engTxDone` sets status bit 0, and a pulse on `engRxDone` sets status bit 1. Both bits hold until they are cleared by a write.
- R6: Status bit 2 (receive data arrived) sets whenever the engine pushes a byte that the receive FIFO accepts.
- R7: Status level bits: bit 3 is 1 while the transmit FIFO has room for at least four bytes, bit 4 is 1 while the receive FIFO is empty, bit 5 is 1 while the transmit FIFO is full, and bit 7 follows `engReady`.
- R8: A write to the byte TX port (0x44) pushes write-data bits 7:0 into the transmit FIFO. The write is dropped if the FIFO is full.
- R9: A read of the byte RX port (0x40) returns the oldest receive byte in bits 7:0 and pops it. If the receive FIFO is empty, the read returns 0 and leaves the FIFO unchanged.
- R10: With the wide-access flag set, a write to the word TX port (0x4C) pushes lanes 0 to 3 in that order, but only if at least four entries are free; otherwise the whole word is dropped. A read of the word RX port (0x48) returns up to four oldest bytes, with lane 0 holding the oldest byte and empty lanes reading 0, and pops the bytes it returns.
- R11: With the wide-access flag clear, the word TX port and word RX port act exactly like the byte ports.
- R12: `irq` is 1 exactly when some status bit in 0 to 5 is 1 and the matching interrupt enable bit is 1.
- R13: `engTxData` shows the oldest transmit byte, and `engTxPop` removes it unless the FIFO is empty. `engRxFull` is 1 while the receive FIFO is full, and an engine push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 7 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| engTxPop | input | 1 | Engine takes one transmit byte |
| engTxData | output | 8 | Oldest transmit byte |
| engTxEmpty | output | 1 | Transmit FIFO empty |
| engRxPush | input | 1 | Engine delivers one receive byte |
| engRxData | input | 8 | Receive byte from engine |
| engRxFull | output | 1 | Receive FIFO full |
| engTxDone | input | 1 | Transmit-complete event pulse |
| engRxDone | input | 1 | Receive-complete event pulse |
| engReady | input | 1 | Engine idle and ready |
| ctrlWord | output | 32 | Control word to engine |
| framesWord | output | 32 | Frames word to engine |
| framesExt | output | 32 | Frames extension word to engine |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so it is due in the access cycle itself. Any pop caused by a read, any register update and any FIFO push take effect at the rising edge that closes the access. Engine pulses therefore become visible in status and on `irq` one edge after they are driven, and `engTxData` moves one edge after a pop.

The bench drives every input on the falling edge. It samples read data and engine-side outputs 2 ns later, before the next rising edge. Every effect is then checked in the cycle after the edge that produced it and never in the same cycle. For the set-versus-clear collision, both the event and the clear are driven in a single falling-edge window.

// File: rtl/sflash_regfront_pkg.sv
package sflash_regfront_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 7;
  localparam int LANES  = 4;
  localparam int N_W    = $clog2(LANES + 1);
  localparam int IEN_W  = 6;
  localparam int STAT_W = 9;
  localparam int X4_BIT = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAMES = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_RXBYTE = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_TXBYTE = 7'h44;
  localparam logic [ADDR_W-1:0] OFS_RXWORD = 7'h48;
  localparam logic [ADDR_W-1:0] OFS_TXWORD = 7'h4C;
  localparam logic [ADDR_W-1:0] OFS_EXT    = 7'h50;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_FRAMES, RD_IEN, RD_STATUS, RD_RXB, RD_RXW, RD_EXT
  } rdSel_e;

  typedef struct packed {
    logic           wrCtrl;
    logic           wrFrames;
    logic           wrIen;
    logic           wrW1c;
    logic           wrExt;
    logic [N_W-1:0] txPushN;
    logic [N_W-1:0] rxPopN;
    rdSel_e         rdSel;
  } strobe_t;
endpackage

// File: rtl/sflash_lanefifo.sv
module sflash_lanefifo
  import sflash_regfront_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [N_W-1:0]               pushN,
  input  logic [LANES*8-1:0]           pushData,
  input  logic [N_W-1:0]               popN,
  output logic [LANES*8-1:0]           peek,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      count <= count + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (N_W'(k) < pushN) mem[wrPtr + PTR_W'(k)] <= pushData[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      peek[8*k +: 8] = (CNT_W'(k) < count) ? mem[rdPtr + PTR_W'(k)] : 8'h00;
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, count} + (CNT_W+1)'(pushN)) <= (CNT_W+1)'(DEPTH)); // R8
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(popN) <= count); // R9
endmodule

// File: rtl/sflash_regctl.sv
module sflash_regctl
  import sflash_regfront_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                             busSel,
  input  logic                             busWrite,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             x4Mode,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]  txCount,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]  rxCount,
  output strobe_t                          strobes
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

  logic [CNT_W-1:0] txFree;
  logic             txHasOne;
  logic             txHasWord;
  logic [N_W-1:0]   rxWordPop;
  logic [N_W-1:0]   rxBytePop;
  logic             doWr;
  logic             doRd;

  always_comb begin
    txFree    = DEPTH_C - txCount;
    txHasOne  = txFree != '0;
    txHasWord = txFree >= LANES_C;
    rxBytePop = N_W'(rxCount != '0);
    rxWordPop = (rxCount >= LANES_C) ? N_W'(LANES) : N_W'(rxCount);
    doWr      = busSel && busWrite;
    doRd      = busSel && !busWrite;
  end

  always_comb begin
    strobes = '0;
    strobes.rdSel = RD_NONE;
    case (busAddr)
      OFS_CTRL:   begin strobes.wrCtrl   = doWr; strobes.rdSel = RD_CTRL;   end
      OFS_FRAMES: begin strobes.wrFrames = doWr; strobes.rdSel = RD_FRAMES; end
      OFS_IEN:    begin strobes.wrIen    = doWr; strobes.rdSel = RD_IEN;    end
      OFS_STATUS: begin strobes.wrW1c    = doWr; strobes.rdSel = RD_STATUS; end
      OFS_EXT:    begin strobes.wrExt    = doWr; strobes.rdSel = RD_EXT;    end
      OFS_RXBYTE: begin
        strobes.rdSel  = RD_RXB;
        strobes.rxPopN = doRd ? rxBytePop : '0;
      end
      OFS_RXWORD: begin
        strobes.rdSel  = RD_RXW;
        if (doRd) strobes.rxPopN = x4Mode ? rxWordPop : rxBytePop;
      end
      OFS_TXBYTE: strobes.txPushN = N_W'(doWr && txHasOne);
      OFS_TXWORD: begin
        if (x4Mode) strobes.txPushN = (doWr && txHasWord) ? N_W'(LANES) : '0;
        else        strobes.txPushN = N_W'(doWr && txHasOne);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sflash_regdp.sv
module sflash_regdp
  import sflash_regfront_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strobes,
  input  logic [BUS_W-1:0]                 busWdata,
  output logic [BUS_W-1:0]                 busRdata,
  input  logic                             engTxPop,
  output logic [7:0]                       engTxData,
  output logic                             engTxEmpty,
  input  logic                             engRxPush,
  input  logic [7:0]                       engRxData,
  output logic                             engRxFull,
  input  logic                             engTxDone,
  input  logic                             engRxDone,
  input  logic                             engReady,
  output logic [BUS_W-1:0]                 ctrlWord,
  output logic [BUS_W-1:0]                 framesWord,
  output logic [BUS_W-1:0]                 framesExt,
  output logic                             irq,
  output logic                             x4Mode,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  txCount,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  rxCount
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

  logic [IEN_W-1:0]   ienReg;
  logic               stTxDone;
  logic               stRxDone;
  logic               stRxAvail;
  logic [STAT_W-1:0]  statusVec;
  logic [LANES*8-1:0] txPeek;
  logic [LANES*8-1:0] rxPeek;
  logic [N_W-1:0]     txPopN;
  logic [N_W-1:0]     rxPushN;
  logic               rxAccept;

  assign x4Mode     = ctrlWord[X4_BIT];
  assign engTxEmpty = txCount == '0;
  assign engRxFull  = rxCount == DEPTH_C;
  assign engTxData  = txPeek[7:0];
  assign rxAccept   = engRxPush && !engRxFull;
  assign txPopN     = N_W'(engTxPop && !engTxEmpty);
  assign rxPushN    = N_W'(rxAccept);

  sflash_lanefifo #(.DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .pushN(strobes.txPushN), .pushData(busWdata),
    .popN(txPopN), .peek(txPeek), .count(txCount)
  );

  sflash_lanefifo #(.DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .pushN(rxPushN),
    .pushData({{(LANES-1)*8{1'b0}}, engRxData}),
    .popN(strobes.rxPopN), .peek(rxPeek), .count(rxCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord   <= '0;
      framesWord <= '0;
      framesExt  <= '0;
      ienReg     <= '0;
    end else begin
      if (strobes.wrCtrl)   ctrlWord   <= busWdata;
      if (strobes.wrFrames) framesWord <= busWdata;
      if (strobes.wrExt)    framesExt  <= busWdata;
      if (strobes.wrIen)    ienReg     <= busWdata[IEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stTxDone  <= 1'b0;
      stRxDone  <= 1'b0;
      stRxAvail <= 1'b0;
    end else begin
      stTxDone  <= engTxDone | (stTxDone  & !(strobes.wrW1c && busWdata[0]));
      stRxDone  <= engRxDone | (stRxDone  & !(strobes.wrW1c && busWdata[1]));
      stRxAvail <= rxAccept  | (stRxAvail & !(strobes.wrW1c && busWdata[2]));
    end
  end

  always_comb begin
    statusVec = {x4Mode, engReady, 1'b0,
                 txCount == DEPTH_C,
                 rxCount == '0,
                 (DEPTH_C - txCount) >= LANES_C,
                 stRxAvail, stRxDone, stTxDone};
    irq = |(statusVec[IEN_W-1:0] & ienReg);
  end

  always_comb begin
    case (strobes.rdSel)
      RD_CTRL:   busRdata = ctrlWord;
      RD_FRAMES: busRdata = framesWord;
      RD_EXT:    busRdata = framesExt;
      RD_IEN:    busRdata = BUS_W'(ienReg);
      RD_STATUS: busRdata = BUS_W'(statusVec);
      RD_RXB:    busRdata = BUS_W'(rxPeek[7:0]);
      RD_RXW:    busRdata = x4Mode ? BUS_W'(rxPeek) : BUS_W'(rxPeek[7:0]);
      default:   busRdata = '0;
    endcase
  end

  AST_TXDONE_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    engTxDone |=> statusVec[0]); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrW1c && busWdata[1] && !engRxDone) |=> !statusVec[1]); // R4
  AST_RXAVAIL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && !engRxFull) |=> statusVec[2]); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdSel == RD_RXB && rxCount == '0) |-> busRdata == '0); // R9
endmodule

// File: rtl/sflash_regfront.sv
module sflash_regfront
  import sflash_regfront_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [6:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  output logic        engTxEmpty,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  output logic        engRxFull,
  input  logic        engTxDone,
  input  logic        engRxDone,
  input  logic        engReady,
  output logic [31:0] ctrlWord,
  output logic [31:0] framesWord,
  output logic [31:0] framesExt,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  strobe_t          strobes;
  logic             x4Mode;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  sflash_regctl #(.FIFO_DEPTH(FIFO_DEPTH)) uCtl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .x4Mode(x4Mode), .txCount(txCount), .rxCount(rxCount), .strobes(strobes)
  );

  sflash_regdp #(.FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .busRdata(busRdata), .engTxPop(engTxPop), .engTxData(engTxData),
    .engTxEmpty(engTxEmpty), .engRxPush(engRxPush), .engRxData(engRxData),
    .engRxFull(engRxFull), .engTxDone(engTxDone), .engRxDone(engRxDone),
    .engReady(engReady), .ctrlWord(ctrlWord), .framesWord(framesWord),
    .framesExt(framesExt), .irq(irq), .x4Mode(x4Mode),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: tb/sflash_regfront_test.sv
module sflash_regfront_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engTxPop = 1'b0, engRxPush = 1'b0;
  logic [7:0]  engTxData, engRxData = '0;
  logic        engTxEmpty, engRxFull, irq;
  logic        engTxDone = 1'b0, engRxDone = 1'b0, engReady = 1'b0;
  logic [31:0] ctrlWord, framesWord, framesExt;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sflash_regfront uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .engTxPop(engTxPop), .engTxData(engTxData), .engTxEmpty(engTxEmpty),
    .engRxPush(engRxPush), .engRxData(engRxData), .engRxFull(engRxFull),
    .engTxDone(engTxDone), .engRxDone(engRxDone), .engReady(engReady),
    .ctrlWord(ctrlWord), .framesWord(framesWord), .framesExt(framesExt),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = b;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic txPop(output logic [7:0] b);
    @(negedge clk);
    #2 b = engTxData;
    engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(7'h10, d); chk("R1 status after reset", d, 32'h18);
    rd(7'h00, d); chk("R1 control after reset", d, 0);
    rd(7'h0C, d); chk("R1 ien after reset", d, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 tx empty after reset", {31'b0, engTxEmpty}, 1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(7'h00, 32'h0000_0003); rd(7'h00, d); chk("R2 control readback", d, 32'h3);
    chk("R2 ctrlWord out", ctrlWord, 32'h3);
    wr(7'h04, 32'hDEAD_BEEF); rd(7'h04, d); chk("R2 frames readback", d, 32'hDEADBEEF);
    chk("R2 framesWord out", framesWord, 32'hDEADBEEF);
    wr(7'h50, 32'h1234_5678); rd(7'h50, d); chk("R2 ext readback", d, 32'h12345678);
    chk("R2 framesExt out", framesExt, 32'h12345678);
    wr(7'h0C, 32'hFFFF_FFFF); rd(7'h0C, d); chk("R2 ien keeps 6 bits", d, 32'h3F);
    wr(7'h0C, 0);
  endtask

  task automatic t_mirror();
    logic [31:0] d;
    wr(7'h00, 32'h0001_0003); rd(7'h10, d); chk("R3 x4 mirror set", {31'b0, d[8]}, 1);
    wr(7'h00, 32'h0000_0003); rd(7'h10, d); chk("R3 x4 mirror clear", {31'b0, d[8]}, 0);
    engReady = 1'b1; rd(7'h10, d); chk("R7 ready bit", {31'b0, d[7]}, 1);
    engReady = 1'b0;
  endtask

  task automatic t_latch();
    logic [31:0] d;
    @(negedge clk); engTxDone = 1'b1; @(negedge clk); engTxDone = 1'b0;
    @(negedge clk); engRxDone = 1'b1; @(negedge clk); engRxDone = 1'b0;
    rd(7'h10, d); chk("R5 done bits latched", d & 32'h3, 32'h3);
    wr(7'h10, 32'h0); rd(7'h10, d); chk("R4 write 0 keeps bits", d & 32'h3, 32'h3);
    wr(7'h10, 32'h1); rd(7'h10, d); chk("R4 w1c bit0 only", d & 32'h3, 32'h2);
    wr(7'h10, 32'h2); rd(7'h10, d); chk("R4 w1c bit1", d & 32'h3, 32'h0);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 7'h10; busWdata = 32'h1; engTxDone = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; engTxDone = 1'b0;
    rd(7'h10, d); chk("R4 set wins over clear", {31'b0, d[0]}, 1);
    wr(7'h10, 32'h7);
  endtask

  task automatic t_irq();
    wr(7'h0C, 32'h1);
    #2 chk("R12 irq quiet with bit clear", {31'b0, irq}, 0);
    @(negedge clk); engTxDone = 1'b1; @(negedge clk); engTxDone = 1'b0;
    #2 chk("R12 irq on enabled done", {31'b0, irq}, 1);
    wr(7'h10, 32'h1);
    #2 chk("R12 irq drops after clear", {31'b0, irq}, 0);
    wr(7'h0C, 32'h10);
    #2 chk("R12 irq on rx empty level", {31'b0, irq}, 1);
    wr(7'h0C, 32'h0);
    #2 chk("R12 irq masked", {31'b0, irq}, 0);
  endtask

  task automatic t_byteTx();
    logic [31:0] d;
    logic [7:0] b;
    wr(7'h44, 32'hFFFF_FFA1); wr(7'h44, 32'h0000_00B2);
    #2 chk("R13 tx not empty", {31'b0, engTxEmpty}, 0);
    txPop(b); chk("R8 first byte", {24'b0, b}, 32'hA1);
    txPop(b); chk("R8 second byte", {24'b0, b}, 32'hB2);
    #2 chk("R13 tx empty after drain", {31'b0, engTxEmpty}, 1);
    for (int i = 0; i < 8; i++) wr(7'h44, i);
    rd(7'h10, d);
    chk("R7 tx full bit", {31'b0, d[5]}, 1);
    chk("R7 tx room bit clear", {31'b0, d[3]}, 0);
    wr(7'h44, 32'h99);
    for (int i = 0; i < 8; i++) begin
      txPop(b); chk("R8 full-drop order", {24'b0, b}, i);
    end
    #2 chk("R8 dropped byte absent", {31'b0, engTxEmpty}, 1);
    @(negedge clk); engTxPop = 1'b1; @(negedge clk); engTxPop = 1'b0;
    wr(7'h44, 32'h5A);
    txPop(b); chk("R13 pop on empty ignored", {24'b0, b}, 32'h5A);
  endtask

  task automatic t_byteRx();
    logic [31:0] d;
    rd(7'h10, d); chk("R6 rx-arrived clear", {31'b0, d[2]}, 0);
    rxPush(8'h11); rxPush(8'h22);
    rd(7'h10, d);
    chk("R6 rx-arrived set", {31'b0, d[2]}, 1);
    chk("R7 rx empty clear", {31'b0, d[4]}, 0);
    rd(7'h40, d); chk("R9 byte read 1", d, 32'h11);
    rd(7'h40, d); chk("R9 byte read 2", d, 32'h22);
    rd(7'h40, d); chk("R9 empty read zero", d, 0);
    rxPush(8'h33);
    rd(7'h40, d); chk("R9 empty read no pop", d, 32'h33);
    wr(7'h10, 32'h4); rd(7'h10, d); chk("R4 w1c bit2", {31'b0, d[2]}, 0);
  endtask

  task automatic t_wordRx();
    logic [31:0] d;
    wr(7'h00, 32'h0001_0003);
    for (int i = 0; i < 9; i++) rxPush(8'h50 + 8'(i));
    #2 chk("R13 rx full", {31'b0, engRxFull}, 1);
    rd(7'h48, d); chk("R10 word read lanes", d, 32'h53525150);
    rd(7'h48, d); chk("R10 word read second", d, 32'h57565554);
    rd(7'h10, d); chk("R13 ninth byte dropped", {31'b0, d[4]}, 1);
    rxPush(8'hAA); rxPush(8'hBB);
    rd(7'h48, d); chk("R10 partial word zero-fill", d, 32'h0000BBAA);
    rd(7'h10, d); chk("R10 partial word pops all", {31'b0, d[4]}, 1);
  endtask

  task automatic t_wordTx();
    logic [31:0] d;
    logic [7:0] b;
    wr(7'h4C, 32'h0302_0100); wr(7'h4C, 32'h0706_0504);
    wr(7'h4C, 32'h0B0A_0908);
    txPop(b); chk("R10 lane 0 first", {24'b0, b}, 0);
    wr(7'h4C, 32'h0F0E_0D0C);
    rd(7'h10, d); chk("R7 room bit with 1 free", {31'b0, d[3]}, 0);
    for (int i = 1; i < 8; i++) begin
      txPop(b); chk("R10 word order, partial room dropped", {24'b0, b}, i);
    end
    #2 chk("R10 no extra bytes", {31'b0, engTxEmpty}, 1);
  endtask

  task automatic t_noX4();
    logic [31:0] d;
    logic [7:0] b;
    wr(7'h00, 32'h0000_0003);
    wr(7'h4C, 32'h00CC_BBAA);
    txPop(b); chk("R11 word tx single byte", {24'b0, b}, 32'hAA);
    #2 chk("R11 only one byte pushed", {31'b0, engTxEmpty}, 1);
    rxPush(8'h61); rxPush(8'h62);
    rd(7'h48, d); chk("R11 word rx single byte 1", d, 32'h61);
    rd(7'h48, d); chk("R11 word rx single byte 2", d, 32'h62);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_mirror();
    t_latch();
    t_irq();
    t_byteTx();
    t_byteRx();
    t_wordRx();
    t_wordTx();
    t_noX4();
    summary();
  end
endmodule